// File: doc/BRIEF.md
# Time-Interleaved Multichannel NCO

This block generates sine and cosine samples for several independent oscillator channels. All channels share one phase-to-amplitude datapath. It suits designs where the clock runs far faster than any single channel needs to be sampled. Each channel keeps its own phase step, phase offset and phase accumulator. A slot counter visits the channels in a fixed round-robin order, servicing one channel per clock.

Every serviced slot produces one sample on the output two clocks later. Each sample is tagged with its channel number, a frame-start flag for channel 0, and a valid flag. The result is one interleaved stream of samples. Software-side logic loads each channel's step or offset through a single write port.

The phase-to-amplitude map is a small quarter-wave table, computed at elaboration. The two top phase bits choose whether the table is read mirrored and whether the result is negated.

Top module: `nco_mc`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0. Reset clears every accumulator, step and offset to 0 and returns the slot counter to channel 0.
- R2: Serviced slots visit channels 0, 1, …, NUM_CH−1 and then wrap to 0. `out_first` is 1 exactly on valid samples of channel 0.
- R3: A slot serviced on clock edge k, which happens when `run` is high at that edge, produces a sample with `out_valid`=1 after edge k+1.
- R4: The phase used for a serviced channel is its accumulator plus its offset, modulo 2^PHASE_W. The accumulator then grows by the channel's step, and only on that channel's own slots.
- R5: Let u be the top LUT_AW+2 bits of the phase and A = 2^(OUT_W−1)−1. Then `out_sin` is within A/256+2 of A·sin(2π(u+0.5)/2^(LUT_AW+2)). Here u bit LUT_AW selects a mirrored table read, and u bit LUT_AW+1 selects negation.
- R6: `out_cos` obeys the same rule as `out_sin` with u advanced by one quarter turn (2^LUT_AW).
- R7: A step write (`cfg_we`=1, `cfg_sel`=0) is applied at a clock edge. A service of that channel at the same edge still uses the old step. Later services use the new step.
- R8: An offset write (`cfg_sel`=1) follows the same timing as R7 and changes the phase of later samples of that channel without touching its accumulator.
- R9: With `run` low, no slot is serviced, and the slot counter and accumulators hold. Two clocks later `out_valid` is 0. When `run` returns high, servicing resumes at the held channel.
- R10: A write whose `cfg_ch` is NUM_CH or above changes no channel's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Service one slot on this clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: phase step, 1: phase offset |
| cfg_ch | input | CH_W | Channel written |
| cfg_data | input | PHASE_W | Value written |
| out_valid | output | 1 | Sample present |
| out_ch | output | CH_W | Channel of the sample |
| out_first | output | 1 | Sample belongs to channel 0 |
| out_sin | output | OUT_W | Signed sine sample |
| out_cos | output | OUT_W | Signed cosine sample |

## Verification
The bench builds the block with five channels, a 20-bit phase, a 64-entry quarter table and 16-bit samples. Five channels is not a power of two, so the slot counter must wrap before its natural overflow. It also leaves channel codes 5 to 7 free for the ignored-write case. The 20-bit phase makes a step of all ones act as a small negative step, which walks the phase backwards through every quadrant. Together these drive both mirrored and negated table reads.

// File: rtl/nco_mc_pkg.sv
package nco_mc_pkg;

    typedef enum logic {
        CFG_STEP   = 1'b0,
        CFG_OFFSET = 1'b1
    } cfg_kind_e;

    // Rational sine approximation over a half cycle, sampled at the centre
    // of quarter-table entry k (half-step offset keeps mirroring exact).
    function automatic longint quarter_sine(input int k, input int aw, input int amp);
        longint h;
        longint x;
        longint num;
        longint den;
        h   = longint'(4) << aw;
        x   = longint'(2 * k + 1);
        num = 16 * x * (h - x);
        den = 5 * h * h - 4 * x * (h - x);
        return (longint'(amp) * num + den / 2) / den;
    endfunction

    function automatic int ch_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/nco_mc_sched.sv
module nco_mc_sched #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    output logic [CH_W-1:0] slot_ch
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ch <= '0;
        end else if (run) begin
            slot_ch <= (slot_ch == LAST) ? '0 : slot_ch + CH_W'(1);
        end
    end
endmodule

// File: rtl/nco_mc_phase.sv
module nco_mc_phase
    import nco_mc_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int CH_W    = 2,
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CH_W-1:0]    slot_ch,
    input  logic               cfg_we,
    input  cfg_kind_e          cfg_kind,
    input  logic [CH_W-1:0]    cfg_ch,
    input  logic [PHASE_W-1:0] cfg_data,
    output logic               st_valid,
    output logic [CH_W-1:0]    st_ch,
    output logic               st_first,
    output logic [PHASE_W-1:0] st_phase
);
    logic [PHASE_W-1:0] tap [NUM_CH];
    logic [PHASE_W-1:0] sel_phase;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [PHASE_W-1:0] acc_r;
        logic [PHASE_W-1:0] step_r;
        logic [PHASE_W-1:0] ofs_r;
        logic               hit;
        logic               wr;

        assign hit = run && (slot_ch == CH_W'(i));
        assign wr  = cfg_we && (cfg_ch == CH_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_r  <= '0;
                step_r <= '0;
                ofs_r  <= '0;
            end else begin
                if (hit) begin
                    acc_r <= acc_r + step_r;
                end
                if (wr && cfg_kind == CFG_STEP) begin
                    step_r <= cfg_data;
                end
                if (wr && cfg_kind == CFG_OFFSET) begin
                    ofs_r <= cfg_data;
                end
            end
        end

        assign tap[i] = acc_r + ofs_r;
    end

    always_comb begin
        sel_phase = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot_ch == CH_W'(i)) begin
                sel_phase = tap[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st_ch    <= '0;
            st_first <= 1'b0;
            st_phase <= '0;
        end else begin
            st_valid <= run;
            st_ch    <= slot_ch;
            st_first <= run && (slot_ch == '0);
            st_phase <= sel_phase;
        end
    end
endmodule

// File: rtl/nco_mc_wave.sv
module nco_mc_wave
    import nco_mc_pkg::*;
#(
    parameter int CH_W    = 2,
    parameter int PHASE_W = 24,
    parameter int LUT_AW  = 6,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    input  logic [CH_W-1:0]         st_ch,
    input  logic                    st_first,
    input  logic [PHASE_W-1:0]      st_phase,
    output logic                    out_valid,
    output logic [CH_W-1:0]         out_ch,
    output logic                    out_first,
    output logic signed [OUT_W-1:0] out_sin,
    output logic signed [OUT_W-1:0] out_cos
);
    localparam int DEPTH  = 1 << LUT_AW;
    localparam int CODE_W = LUT_AW + 2;
    localparam int AMP    = (1 << (OUT_W - 1)) - 1;

    typedef struct packed {
        logic        mirror;
        logic        negate;
        logic [LUT_AW-1:0] idx;
    } lut_ref_t;

    logic [OUT_W-1:0]  rom [DEPTH];
    logic [CODE_W-1:0] code_s;
    logic [CODE_W-1:0] code_c;
    lut_ref_t          ref_s;
    lut_ref_t          ref_c;
    logic [OUT_W-1:0]  mag_s;
    logic [OUT_W-1:0]  mag_c;
    logic signed [OUT_W-1:0] val_s;
    logic signed [OUT_W-1:0] val_c;

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        localparam longint VAL = quarter_sine(k, LUT_AW, AMP);
        assign rom[k] = VAL[OUT_W-1:0];
    end

    always_comb begin
        code_s = st_phase[PHASE_W-1 -: CODE_W];
        code_c = code_s + CODE_W'(DEPTH);
        ref_s  = '{mirror: code_s[LUT_AW], negate: code_s[LUT_AW+1], idx: code_s[LUT_AW-1:0]};
        ref_c  = '{mirror: code_c[LUT_AW], negate: code_c[LUT_AW+1], idx: code_c[LUT_AW-1:0]};
        mag_s  = ref_s.mirror ? rom[~ref_s.idx] : rom[ref_s.idx];
        mag_c  = ref_c.mirror ? rom[~ref_c.idx] : rom[ref_c.idx];
        val_s  = ref_s.negate ? -$signed(mag_s) : $signed(mag_s);
        val_c  = ref_c.negate ? -$signed(mag_c) : $signed(mag_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_first <= 1'b0;
            out_sin   <= '0;
            out_cos   <= '0;
        end else begin
            out_valid <= st_valid;
            out_ch    <= st_ch;
            out_first <= st_first && st_valid;
            out_sin   <= val_s;
            out_cos   <= val_c;
        end
    end
endmodule

// File: rtl/nco_mc.sv
module nco_mc
    import nco_mc_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int PHASE_W = 24,
    parameter int LUT_AW  = 6,
    parameter int OUT_W   = 16,
    parameter int CH_W    = ch_bits(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [CH_W-1:0]         cfg_ch,
    input  logic [PHASE_W-1:0]      cfg_data,
    output logic                    out_valid,
    output logic [CH_W-1:0]         out_ch,
    output logic                    out_first,
    output logic signed [OUT_W-1:0] out_sin,
    output logic signed [OUT_W-1:0] out_cos
);
    logic [CH_W-1:0]    slot_ch;
    logic               st_valid;
    logic [CH_W-1:0]    st_ch;
    logic               st_first;
    logic [PHASE_W-1:0] st_phase;
    cfg_kind_e          cfg_kind;

    assign cfg_kind = cfg_kind_e'(cfg_sel);

    nco_mc_sched #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .slot_ch (slot_ch)
    );

    nco_mc_phase #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PHASE_W(PHASE_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .slot_ch  (slot_ch),
        .cfg_we   (cfg_we),
        .cfg_kind (cfg_kind),
        .cfg_ch   (cfg_ch),
        .cfg_data (cfg_data),
        .st_valid (st_valid),
        .st_ch    (st_ch),
        .st_first (st_first),
        .st_phase (st_phase)
    );

    nco_mc_wave #(.CH_W(CH_W), .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_wave (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .st_ch     (st_ch),
        .st_first  (st_first),
        .st_phase  (st_phase),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_first (out_first),
        .out_sin   (out_sin),
        .out_cos   (out_cos)
    );
endmodule

// File: rtl/nco_mc_chk.sv
module nco_mc_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            run,
    input logic [CH_W-1:0] slot_ch,
    input logic            out_valid,
    input logic [CH_W-1:0] out_ch,
    input logic            out_first
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && slot_ch == LAST) |=> (slot_ch == '0)); // R2

    AST_OUT_SEQ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && $past(out_ch) != LAST)
        |-> (out_ch == $past(out_ch) + CH_W'(1))); // R2

    AST_FIRST_TAG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first) |-> (out_ch == '0)); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        run |-> ##2 out_valid); // R3

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !run |-> ##2 !out_valid); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(slot_ch)); // R9
endmodule

bind nco_mc nco_mc_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .slot_ch   (slot_ch),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_first (out_first)
);

// File: tb/tb_nco_mc.sv
module tb_nco_mc;
    localparam int NCH   = 5;
    localparam int PW    = 20;
    localparam int AW    = 6;
    localparam int OW    = 16;
    localparam int CW    = 3;
    localparam int AMP   = (1 << (OW - 1)) - 1;
    localparam int unsigned MASK = (1 << PW) - 1;
    localparam real TOL  = AMP / 256.0 + 2.0;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_sel = 1'b0;
    logic [CW-1:0] cfg_ch = '0;
    logic [PW-1:0] cfg_data = '0;
    logic out_valid;
    logic [CW-1:0] out_ch;
    logic out_first;
    logic signed [OW-1:0] out_sin;
    logic signed [OW-1:0] out_cos;

    int checks = 0;
    int fails = 0;

    int unsigned m_acc [NCH];
    int unsigned m_inc [NCH];
    int unsigned m_off [NCH];
    int m_slot = 0;
    bit e1_v = 0;
    int e1_ch = 0;
    int unsigned e1_ph = 0;

    typedef struct packed {
        logic       sel;
        logic [2:0] ch;
        logic [19:0] data;
        logic [7:0] hold;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 3'd0, 20'h01000, 8'd2},
        '{1'b0, 3'd1, 20'h08000, 8'd2},
        '{1'b0, 3'd2, 20'h10400, 8'd1},
        '{1'b0, 3'd3, 20'hFFFFF, 8'd3},
        '{1'b0, 3'd4, 20'h40000, 8'd2},
        '{1'b1, 3'd2, 20'h40000, 8'd4},
        '{1'b1, 3'd1, 20'h80000, 8'd3},
        '{1'b0, 3'd3, 20'hF8000, 8'd40}
    };

    nco_mc #(.NUM_CH(NCH), .PHASE_W(PW), .LUT_AW(AW), .OUT_W(OW)) dut (
        .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_ch(cfg_ch), .cfg_data(cfg_data), .out_valid(out_valid), .out_ch(out_ch),
        .out_first(out_first), .out_sin(out_sin), .out_cos(out_cos)
    );

    always #2 clk = ~clk;

    function automatic real ideal(input int unsigned ph, input bit cosine);
        int unsigned u;
        u = ph >> (PW - (AW + 2));
        if (cosine) u = (u + (1 << AW)) % (1 << (AW + 2));
        return AMP * $sin(TWO_PI * (real'(u) + 0.5) / real'(1 << (AW + 2)));
    endfunction

    task automatic chk(input bit ok, input string req, input string tag,
                       input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_acc[i] = 0; m_inc[i] = 0; m_off[i] = 0;
        end
        m_slot = 0; e1_v = 0; e1_ch = 0; e1_ph = 0;
    endtask

    task automatic tick(input string tag);
        bit xv;
        int xch;
        int unsigned xph;
        real es;
        real ec;
        xv = e1_v; xch = e1_ch; xph = e1_ph;
        if (run) begin
            e1_v = 1; e1_ch = m_slot;
            e1_ph = (m_acc[m_slot] + m_off[m_slot]) & MASK;
            m_acc[m_slot] = (m_acc[m_slot] + m_inc[m_slot]) & MASK;
            m_slot = (m_slot == NCH - 1) ? 0 : m_slot + 1;
        end else begin
            e1_v = 0;
        end
        if (cfg_we && int'(cfg_ch) < NCH) begin
            if (cfg_sel) m_off[cfg_ch] = cfg_data;
            else         m_inc[cfg_ch] = cfg_data;
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == xv, "R3", tag, "valid", int'(out_valid), int'(xv));
        if (xv && out_valid) begin
            chk(int'(out_ch) == xch, "R2", tag, "channel", int'(out_ch), xch);
            chk(out_first == (xch == 0), "R2", tag, "first flag", int'(out_first), int'(xch == 0));
            es = ideal(xph, 1'b0);
            ec = ideal(xph, 1'b1);
            chk((real'(out_sin) - es) <= TOL && (es - real'(out_sin)) <= TOL,
                "R4 R5", tag, "sine", int'(out_sin), int'(es));
            chk((real'(out_cos) - ec) <= TOL && (ec - real'(out_cos)) <= TOL,
                "R6", tag, "cosine", int'(out_cos), int'(ec));
        end
    endtask

    task automatic write(input bit sel, input int ch, input int unsigned data, input string tag);
        cfg_we = 1'b1; cfg_sel = sel; cfg_ch = CW'(ch); cfg_data = PW'(data);
        tick(tag);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; run = 1'b0; cfg_we = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset", "valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        tick("R1");
        chk(out_valid == 1'b0, "R1", "after reset", "valid", int'(out_valid), 0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: all-zero state gives phase 0 samples on every channel
        run = 1'b1;
        repeat (2 * NCH) tick("R1");

        // vector table: writes interleaved with running slots (R4 R7 R8)
        for (int v = 0; v < 8; v++) begin
            write(VEC[v].sel, int'(VEC[v].ch), int'(VEC[v].data), "table");
            repeat (int'(VEC[v].hold)) tick("table");
        end

        // R7: step write on the same edge that services the channel
        while (m_slot != 2) tick("R7");
        write(1'b0, 2, 32'h2A000, "R7");
        repeat (3 * NCH) tick("R7");

        // R8: offset write, accumulator untouched
        write(1'b1, 4, 32'hC0000, "R8");
        repeat (3 * NCH) tick("R8");

        // R10: writes to channel codes beyond the last channel are ignored
        write(1'b0, 6, 32'h33333, "R10");
        write(1'b1, 7, 32'h55555, "R10");
        write(1'b0, 5, 32'h77777, "R10");
        repeat (3 * NCH) tick("R10");

        // R9: stall, valid drops after two clocks, resume at held channel
        run = 1'b0;
        tick("R9");
        tick("R9");
        chk(out_valid == 1'b0, "R9", "stall", "valid", int'(out_valid), 0);
        repeat (5) tick("R9");
        run = 1'b1;
        repeat (2 * NCH) tick("R9");
        run = 1'b0; tick("R9"); run = 1'b1; tick("R9");
        run = 1'b0; tick("R9"); tick("R9"); run = 1'b1;
        repeat (2 * NCH) tick("R9");

        // R1: reset mid-run clears steps, offsets and accumulators
        do_reset();
        run = 1'b1;
        repeat (2 * NCH) tick("R1");

        // long run exercising all quadrants
        write(1'b0, 0, 32'h0F0F0, "sweep");
        write(1'b0, 3, 32'hFFF00, "sweep");
        repeat (400) tick("sweep");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule